// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns a start-bit-framed serial line into parallel characters. A programmable rate generator produces a tick at sixteen times the bit rate. A prescaler picks the base clock divided by 1, 8 or 32, and an 8-bit divider then divides by n+1. While reception is enabled, the sampler watches the synchronised line for a low level. It confirms the start bit at its midpoint, then takes one sample per bit in the middle of each bit time. Characters can be 7, 8 or 9 bits long, with optional odd or even parity and one or two stop bits.

Each completed character is copied into a receive buffer. If the previous character was read, a one-cycle interrupt pulse is raised. If it was not read, the buffer is still overwritten, but an overrun is flagged and no pulse is raised. Framing and parity problems set sticky flags, and a single summary flag ORs all three. The host empties the buffer with a one-cycle read strobe. A ready output tells a flow-control driver that a new character can be accepted.

Top module: `serial_rx_core`

## Requirements
- R1: While `rx_en` is 0 no frame is received: the line is ignored, `rx_irq` stays 0 and `rx_data` keeps its value.
- R2: A low level that is high again at the middle of the start bit is dropped as noise and starts no character.
- R3: `char_len` selects the character size: 0 gives 7 bits, 1 gives 8 bits and 2 gives 9 bits. The first data bit on the line is bit 0 of `rx_data`, and unused upper bits of `rx_data` read 0.
- R4: One bit lasts 16·(n+1)·P clock cycles, where n is `baud_n`. P is 1, 8 or 32 for `clk_sel` values 0, 1 and 2.
- R5: A character that completes while the buffer is empty loads `rx_data` and raises `rx_irq` for exactly one cycle.
- R6: A character that completes while the buffer holds an unread character overwrites `rx_data`, sets `ovr_err` and raises no `rx_irq`.
- R7: A one-cycle `rd_strobe` marks the buffer empty and clears `ovr_err`.
- R8: `two_stop` = 1 expects two stop bits and 0 expects one. If any expected stop bit is sampled low, `frm_err` is set.
- R9: With `par_en` = 1, one parity bit follows the data. `par_odd` = 1 requires an odd count of ones over the data and parity bits, and 0 requires an even count. A mismatch sets `par_err`.
- R10: `err_sum` is 1 exactly when at least one of `ovr_err`, `frm_err` or `par_err` is 1.
- R11: One cycle with `rx_en` = 0 clears `ovr_err`, `frm_err` and `par_err`. Until then, `frm_err` and `par_err` remain set.
- R12: `rx_ready` is 1 exactly when `rx_en` is 1 and the buffer holds no unread character. Reset leaves the buffer empty and `rx_data` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial data line, idle high |
| clk_sel | input | 2 | Prescaler select: 0 = /1, 1 = /8, 2 = /32 |
| baud_n | input | 8 | Divider setting n, divides by n+1 |
| char_len | input | 2 | Character size code: 0 = 7, 1 = 8, 2 = 9 bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| rd_strobe | input | 1 | Host read of the receive buffer |
| rx_data | output | 9 | Receive buffer, right-aligned |
| rx_irq | output | 1 | One-cycle pulse on a buffer load |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |
| rx_ready | output | 1 | Ready to accept a new character |

## Verification
The embedded properties assume that the format and rate inputs (`char_len`, `par_en`, `par_odd`, `two_stop`, `clk_sel`, `baud_n`) stay constant while a character is being received. In particular, the check on the upper buffer bits relies on the size code not changing between the start bit and the buffer load. The stimulus changes these settings only while the line has been idle for at least one bit time after the previous stop bit. Read strobes are single-cycle pulses issued between frames. Every frame is driven with exactly the bit time the rate settings define, so each mid-bit sample lands inside the intended bit.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_PAR   = 3'd3,
        RX_STOP1 = 3'd4,
        RX_STOP2 = 3'd5
    } rx_state_e;

    localparam logic [1:0] LEN_7 = 2'd0;
    localparam logic [1:0] LEN_8 = 2'd1;
    localparam logic [1:0] LEN_9 = 2'd2;

    localparam logic [1:0] PRE_1  = 2'd0;
    localparam logic [1:0] PRE_8  = 2'd1;

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
    parameter int DIV_W = 8,
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_sel,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick_o
);
    import srx_pkg::*;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] div;
        logic             tick;
    } baud_t;

    baud_t b_d, b_q;
    logic [PRE_W-1:0] pre_lim;

    always_comb begin
        case (clk_sel)
            PRE_1:   pre_lim = '0;
            PRE_8:   pre_lim = PRE_W'(7);
            default: pre_lim = '1;
        endcase
    end

    always_comb begin
        b_d      = b_q;
        b_d.tick = 1'b0;
        if (b_q.pre >= pre_lim) begin
            b_d.pre = '0;
            if (b_q.div >= div_n) begin
                b_d.div  = '0;
                b_d.tick = 1'b1;
            end else begin
                b_d.div = b_q.div + 1'b1;
            end
        end else begin
            b_d.pre = b_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign tick_o = b_q.tick;

    // R4: with a prescale or divide above one, ticks never come back to back
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_q.tick && (clk_sel != PRE_1 || div_n != '0)) |=> !b_q.tick);

endmodule

// File: rtl/srx_frame.sv
module srx_frame #(
    parameter int OS   = 16,
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_en,
    input  logic            rxd,
    input  logic            tick_i,
    input  logic [1:0]      char_len,
    input  logic            par_en,
    input  logic            par_odd,
    input  logic            two_stop,
    output logic            done_o,
    output logic [DMAX-1:0] data_o,
    output logic            frm_o,
    output logic            par_o
);
    import srx_pkg::*;

    localparam int CW  = $clog2(OS);
    localparam int BW  = $clog2(DMAX + 1);
    localparam int MID = OS / 2 - 1;

    typedef struct packed {
        logic [1:0]      sync;
        rx_state_e       state;
        logic [CW-1:0]   cnt;
        logic [BW-1:0]   bidx;
        logic [DMAX-1:0] sh;
        logic            pacc;
        logic            ferr;
        logic            perr;
    } frame_t;

    frame_t f_d, f_q;
    logic [BW-1:0] nbits;
    logic [BW-1:0] shamt;
    logic          rx_s;
    logic          done;

    always_comb begin
        case (char_len)
            LEN_7:   nbits = BW'(7);
            LEN_9:   nbits = BW'(9);
            default: nbits = BW'(8);
        endcase
        shamt = BW'(DMAX) - nbits;
    end

    assign rx_s = f_q.sync[1];

    always_comb begin
        f_d      = f_q;
        done     = 1'b0;
        f_d.sync = {f_q.sync[0], rxd};
        if (!rx_en) begin
            f_d.state = RX_IDLE;
            f_d.cnt   = '0;
        end else if (tick_i) begin
            case (f_q.state)
                RX_IDLE: begin
                    if (!rx_s) begin
                        f_d.state = RX_START;
                        f_d.cnt   = '0;
                        f_d.bidx  = '0;
                        f_d.sh    = '0;
                        f_d.pacc  = 1'b0;
                        f_d.ferr  = 1'b0;
                        f_d.perr  = 1'b0;
                    end
                end
                RX_START: begin
                    if (f_q.cnt == CW'(MID)) begin
                        f_d.cnt   = '0;
                        f_d.state = rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (f_q.cnt == CW'(OS - 1)) begin
                        f_d.cnt = '0;
                        case (f_q.state)
                            RX_DATA: begin
                                f_d.sh   = {rx_s, f_q.sh[DMAX-1:1]};
                                f_d.pacc = f_q.pacc ^ rx_s;
                                f_d.bidx = f_q.bidx + 1'b1;
                                if (f_q.bidx == nbits - 1'b1)
                                    f_d.state = par_en ? RX_PAR : RX_STOP1;
                            end
                            RX_PAR: begin
                                f_d.perr  = ((f_q.pacc ^ rx_s) != par_odd);
                                f_d.state = RX_STOP1;
                            end
                            RX_STOP1: begin
                                if (!rx_s) f_d.ferr = 1'b1;
                                if (two_stop) begin
                                    f_d.state = RX_STOP2;
                                end else begin
                                    f_d.state = RX_IDLE;
                                    done      = 1'b1;
                                end
                            end
                            default: begin
                                if (!rx_s) f_d.ferr = 1'b1;
                                f_d.state = RX_IDLE;
                                done      = 1'b1;
                            end
                        endcase
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q       <= '0;
            f_q.sync  <= 2'b11;
            f_q.state <= RX_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign done_o = done;
    assign data_o = f_q.sh >> shamt;
    assign frm_o  = f_d.ferr;
    assign par_o  = f_q.perr;

    // R4: a character only completes on a rate tick
    p_done_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> tick_i);

    // R1: with reception disabled the sampler sits idle
    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (f_q.state == RX_IDLE));

endmodule

// File: rtl/srx_status.sv
module srx_status #(
    parameter int DMAX = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_en,
    input  logic            rd_i,
    input  logic            done_i,
    input  logic [DMAX-1:0] data_i,
    input  logic            frm_i,
    input  logic            par_i,
    input  logic [1:0]      char_len,
    output logic [DMAX-1:0] buf_o,
    output logic            full_o,
    output logic            irq_o,
    output logic            ovr_o,
    output logic            frm_o,
    output logic            par_o,
    output logic            sum_o
);
    import srx_pkg::*;

    typedef struct packed {
        logic [DMAX-1:0] data;
        logic            full;
        logic            irq;
        logic            ovr;
        logic            frm;
        logic            par;
        logic            sum;
    } stat_t;

    stat_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        if (rd_i) begin
            s_d.full = 1'b0;
            s_d.ovr  = 1'b0;
        end
        if (!rx_en) begin
            s_d.ovr = 1'b0;
            s_d.frm = 1'b0;
            s_d.par = 1'b0;
        end else if (done_i) begin
            s_d.data = data_i;
            if (s_d.full) begin
                s_d.ovr = 1'b1;
            end else begin
                s_d.full = 1'b1;
                s_d.irq  = 1'b1;
            end
            s_d.frm = s_q.frm | frm_i;
            s_d.par = s_q.par | par_i;
        end
        s_d.sum = s_d.ovr | s_d.frm | s_d.par;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign buf_o  = s_q.data;
    assign full_o = s_q.full;
    assign irq_o  = s_q.irq;
    assign ovr_o  = s_q.ovr;
    assign frm_o  = s_q.frm;
    assign par_o  = s_q.par;
    assign sum_o  = s_q.sum;

    // R5: the interrupt is a single-cycle pulse
    p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R6: the load that causes an overrun raises no interrupt
    p_ovr_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !$past(ovr_o)) |-> !irq_o);

    // R11: disabling reception clears every error flag
    p_disable_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !(ovr_o || frm_o || par_o));

    // R10: summary flag tracks the three error flags
    p_sum_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sum_o == (ovr_o || frm_o || par_o));

    // R3: a 7-bit character leaves the two top buffer bits at zero
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && char_len == LEN_7) |-> (buf_o[DMAX-1:DMAX-2] == 2'b00));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
    parameter int DIV_W = 8,
    parameter int OS    = 16,
    parameter int DMAX  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             rxd,
    input  logic [1:0]       clk_sel,
    input  logic [DIV_W-1:0] baud_n,
    input  logic [1:0]       char_len,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             two_stop,
    input  logic             rd_strobe,
    output logic [DMAX-1:0]  rx_data,
    output logic             rx_irq,
    output logic             ovr_err,
    output logic             frm_err,
    output logic             par_err,
    output logic             err_sum,
    output logic             rx_ready
);
    logic            tick;
    logic            done;
    logic [DMAX-1:0] fr_data;
    logic            fr_frm;
    logic            fr_par;
    logic            full;

    srx_baud #(.DIV_W(DIV_W), .PRE_W(5)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .div_n   (baud_n),
        .tick_o  (tick)
    );

    srx_frame #(.OS(OS), .DMAX(DMAX)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .rxd      (rxd),
        .tick_i   (tick),
        .char_len (char_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .two_stop (two_stop),
        .done_o   (done),
        .data_o   (fr_data),
        .frm_o    (fr_frm),
        .par_o    (fr_par)
    );

    srx_status #(.DMAX(DMAX)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .rd_i     (rd_strobe),
        .done_i   (done),
        .data_i   (fr_data),
        .frm_i    (fr_frm),
        .par_i    (fr_par),
        .char_len (char_len),
        .buf_o    (rx_data),
        .full_o   (full),
        .irq_o    (rx_irq),
        .ovr_o    (ovr_err),
        .frm_o    (frm_err),
        .par_o    (par_err),
        .sum_o    (err_sum)
    );

    assign rx_ready = rx_en & ~full;

    // R12: ready drops after a load and rises again only through a read
    p_ready_after_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !rd_strobe) |-> !rx_ready);

endmodule

// File: tb/serial_rx_core_tb.sv
`timescale 1ns/1ps
module serial_rx_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] clk_sel = 2'd0;
    logic [7:0] baud_n = 8'd0;
    logic [1:0] char_len = 2'd1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       two_stop = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_irq, ovr_err, frm_err, par_err, err_sum, rx_ready;

    int nchk = 0;
    int nfail = 0;
    int irq_cnt = 0;
    int bitclk = 16;

    always #10 clk = ~clk;

    serial_rx_core u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rxd(rxd),
        .clk_sel(clk_sel), .baud_n(baud_n), .char_len(char_len),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_irq(rx_irq),
        .ovr_err(ovr_err), .frm_err(frm_err), .par_err(par_err),
        .err_sum(err_sum), .rx_ready(rx_ready)
    );

    always @(negedge clk) if (rx_irq) irq_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    task automatic set_fmt(input int nb, input int pm, input int ns);
        char_len = 2'(nb - 7);
        par_en   = (pm != 0);
        par_odd  = (pm == 2);
        two_stop = (ns == 2);
    endtask

    // pm: 0 none, 1 even, 2 odd; badstop bit s forces stop bit s low
    task automatic send(input int d, input int nb, input int pm, input int ns,
                        input int badstop, input bit flip);
        int m;
        bit p;
        m = (1 << nb) - 1;
        rxd = 1'b0;
        #(bitclk * 20);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            #(bitclk * 20);
        end
        if (pm != 0) begin
            p = ^(d & m);
            if (pm == 2) p = ~p;
            if (flip) p = ~p;
            rxd = p;
            #(bitclk * 20);
        end
        for (int s = 0; s < ns; s++) begin
            rxd = badstop[s] ? 1'b0 : 1'b1;
            #(bitclk * 20);
        end
        rxd = 1'b1;
        #(bitclk * 20);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk("R12 reset data", rx_data, 0);
        chk("R12 reset ready (disabled)", rx_ready, 0);
        chk("R10 reset err_sum", err_sum, 0);

        // R1: line ignored while disabled
        set_fmt(8, 0, 1);
        send(8'h5A, 8, 0, 1, 0, 0);
        chk("R1 no irq when disabled", irq_cnt, 0);
        chk("R1 data unchanged", rx_data, 0);

        rx_en = 1'b1;
        @(negedge clk);
        chk("R12 ready when enabled", rx_ready, 1);

        // R3 R5 R9 R8: sweep of formats
        for (int nb = 7; nb <= 9; nb++)
            for (int pm = 0; pm < 3; pm++)
                for (int ns = 1; ns <= 2; ns++)
                    for (int k = 0; k < 4; k++) begin
                        int d, exp;
                        d = (k * 91 + nb * 49 + pm * 7 + ns * 3) & 511;
                        if (k == 0) d = 511;
                        if (k == 1) d = 0;
                        exp = d & ((1 << nb) - 1);
                        set_fmt(nb, pm, ns);
                        base = irq_cnt;
                        send(d, nb, pm, ns, 0, 0);
                        chk("R3 data", rx_data, exp);
                        chk("R5 irq count", irq_cnt, base + 1);
                        chk("R10 no error on clean frame", err_sum, 0);
                        chk("R12 not ready after load", rx_ready, 0);
                        do_read();
                        chk("R7 ready after read", rx_ready, 1);
                    end

        // R4: rate settings
        set_fmt(8, 0, 1);
        clk_sel = 2'd0; baud_n = 8'd5; bitclk = 16 * 6;
        repeat (2 * bitclk) @(negedge clk);
        send(8'hC3, 8, 0, 1, 0, 0);
        chk("R4 /1 n=5 data", rx_data, 8'hC3);
        do_read();
        clk_sel = 2'd1; baud_n = 8'd1; bitclk = 16 * 2 * 8;
        repeat (2 * bitclk) @(negedge clk);
        send(8'h3C, 8, 0, 1, 0, 0);
        chk("R4 /8 n=1 data", rx_data, 8'h3C);
        do_read();
        clk_sel = 2'd2; baud_n = 8'd2; bitclk = 16 * 3 * 32;
        repeat (2 * bitclk) @(negedge clk);
        send(8'hA5, 8, 0, 1, 0, 0);
        chk("R4 /32 n=2 data", rx_data, 8'hA5);
        chk("R4 no error", err_sum, 0);
        do_read();
        clk_sel = 2'd0; baud_n = 8'd0; bitclk = 16;
        repeat (64) @(negedge clk);

        // R2: short low pulse rejected
        base = irq_cnt;
        @(negedge clk) rxd = 1'b0;
        repeat (3) @(negedge clk);
        rxd = 1'b1;
        repeat (4 * bitclk) @(negedge clk);
        chk("R2 glitch no irq", irq_cnt, base);
        chk("R2 glitch no framing", frm_err, 0);
        send(8'h81, 8, 0, 1, 0, 0);
        chk("R2 next frame data", rx_data, 8'h81);
        chk("R2 next frame irq", irq_cnt, base + 1);

        // R6: overrun (buffer holds 0x81 unread)
        base = irq_cnt;
        send(8'h7E, 8, 0, 1, 0, 0);
        chk("R6 overwrite", rx_data, 8'h7E);
        chk("R6 overrun flag", ovr_err, 1);
        chk("R6 no irq", irq_cnt, base);
        chk("R10 sum on overrun", err_sum, 1);
        do_read();
        chk("R7 overrun cleared by read", ovr_err, 0);
        chk("R10 sum cleared", err_sum, 0);

        // R8: framing with one stop bit
        base = irq_cnt;
        send(8'h55, 8, 0, 1, 1, 0);
        chk("R8 frame err one stop", frm_err, 1);
        chk("R8 data still loaded", rx_data, 8'h55);
        chk("R5 irq on framing frame", irq_cnt, base + 1);
        chk("R10 sum on framing", err_sum, 1);
        do_read();
        chk("R11 frm sticky after read", frm_err, 1);
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) rx_en = 1'b1;
        @(negedge clk);
        chk("R11 frm cleared", frm_err, 0);
        chk("R11 sum cleared", err_sum, 0);

        // R8: second of two stop bits low
        set_fmt(8, 0, 2);
        send(8'h12, 8, 0, 2, 2, 0);
        chk("R8 second stop low", frm_err, 1);
        do_read();
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) rx_en = 1'b1;
        repeat (2) @(negedge clk);
        // R8: one stop expected, line low in the would-be second stop
        set_fmt(8, 0, 1);
        send(8'h12, 8, 0, 2, 2, 0);
        chk("R8 extra bit ignored with one stop", frm_err, 0);
        do_read();
        repeat (2 * bitclk) @(negedge clk);
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) rx_en = 1'b1;
        repeat (2) @(negedge clk);

        // R9: parity errors, even and odd
        set_fmt(8, 1, 1);
        send(8'hB7, 8, 1, 1, 0, 1);
        chk("R9 even parity error", par_err, 1);
        chk("R10 sum on parity", err_sum, 1);
        chk("R9 no framing", frm_err, 0);
        do_read();
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) rx_en = 1'b1;
        @(negedge clk);
        chk("R11 par cleared", par_err, 0);
        set_fmt(7, 2, 2);
        send(7'h2B, 7, 2, 2, 0, 1);
        chk("R9 odd parity error", par_err, 1);
        chk("R3 7-bit data", rx_data, 7'h2B);
        do_read();
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk) rx_en = 1'b1;
        @(negedge clk);
        send(7'h2B, 7, 2, 2, 0, 0);
        chk("R9 odd parity good", par_err, 0);
        do_read();

        summary();
        $finish;
    end
endmodule